// File: doc/BRIEF.md
# Double-Buffered Programmable Clock Prescaler

This block divides its input clock down to a one-cycle count-enable pulse for a timer counter that sits next to it. The division ratio is a 16-bit value, and the pulse repeats once every ratio + 1 input cycles, so the factor can be anything from 1 to 65536. Software reaches the ratio through a narrow 8-bit write port, one byte per write.

The ratio is double-buffered. Upper bytes written first are only staged. Writing the low byte assembles a complete value in a preload register. The divider keeps running on its active ratio until the neighbouring timer raises its update event. On that event the preload is copied into the active register and the internal count restarts from zero. Software can therefore change the ratio while the divider is running, and the current period is never cut short or stretched by a half-written value.

Top module: `presc_top`

## Requirements
- R1: After reset the staged bytes, the preload ratio, the active ratio and the internal counter are all 0, so `tick_o` is high on every cycle until a different ratio is activated.
- R2: With an active ratio N and no update event, the internal counter steps 0, 1, … N and then wraps to 0. `tick_o` is high for exactly the one cycle in which the counter equals N, once every N+1 cycles.
- R3: An active ratio of 0 keeps `tick_o` high on every cycle.
- R4: A write with `wr_addr_i` = 1 only stages the high byte. The preload ratio does not change.
- R5: A write with `wr_addr_i` = 0 sets the preload ratio to {staged high byte, `wr_data_i`}, with the low byte in bits 7:0.
- R6: Changing the preload ratio has no effect on `tick_o` until an update event occurs.
- R7: When `update_i` is sampled high, the active ratio takes the preload ratio and the counter restarts at 0. The first tick under the new ratio N comes N cycles after that edge.
- R8: If a high byte is written with no low byte after it, the next update event transfers the last complete preload value.
- R9: A ratio of 0xFFFF gives one tick every 65536 cycles.
- R10: If a low-byte write and an update event fall on the same edge, the update transfers the preload value held before that edge. The new value waits for the next update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 1 | Byte lane select: 1 = high byte, 0 = low byte |
| wr_data_i | input | 8 | Write data byte |
| update_i | input | 1 | Timer update event: loads the active ratio and restarts the count |
| tick_o | output | 1 | One-cycle count-enable pulse |

## Verification
The bench builds the block with its default parameters: 8-bit lanes and two of them, giving a 16-bit ratio. It therefore compares every cycle of a full 65536-cycle period at ratio 0xFFFF. That exercises the counter's top value and the wrap to zero. The same default also covers the cases within small ratios: ratio 0, a high byte left without its low byte, an update that restarts the count mid-period, and a low-byte write on the same edge as an update.

// File: rtl/presc_pkg.sv
package presc_pkg;

  typedef enum logic [1:0] {
    CNT_STEP    = 2'd0,
    CNT_WRAP    = 2'd1,
    CNT_RESTART = 2'd2
  } cnt_op_e;

  function automatic cnt_op_e pick_op(input logic restart, input logic at_top);
    if (restart)     return CNT_RESTART;
    else if (at_top) return CNT_WRAP;
    else             return CNT_STEP;
  endfunction

endpackage

// File: rtl/presc_byte_stage.sv
module presc_byte_stage #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2,
  localparam int CNT_W    = BYTE_W * NUM_BYTES,
  localparam int AW       = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int STG_W    = BYTE_W * (NUM_BYTES - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  preload_o
);

  logic [STG_W-1:0] stage_q;
  logic [CNT_W-1:0] preload_q;
  logic             commit;

  // upper lanes only stage; the lane-0 write completes the value
  for (genvar g = 1; g < NUM_BYTES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[(g-1)*BYTE_W +: BYTE_W] <= '0;
      end else if (wr_en_i && wr_addr_i == AW'(g)) begin
        stage_q[(g-1)*BYTE_W +: BYTE_W] <= wr_data_i;
      end
    end
  end

  assign commit = wr_en_i && (wr_addr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      preload_q <= '0;
    end else if (commit) begin
      preload_q <= {stage_q, wr_data_i};
    end
  end

  assign preload_o = preload_q;

endmodule

// File: rtl/presc_ratio_shadow.sv
module presc_ratio_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic [CNT_W-1:0] active_o
);

  logic [CNT_W-1:0] active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
    end else if (load_i) begin
      active_q <= preload_i;
    end
  end

  assign active_o = active_q;

endmodule

// File: rtl/presc_div_counter.sv
module presc_div_counter
  import presc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_top;
  cnt_op_e          op;

  assign at_top = (cnt_q == limit_i);
  assign op     = pick_op(restart_i, at_top);

  always_comb begin
    unique case (op)
      CNT_RESTART: cnt_d = '0;
      CNT_WRAP:    cnt_d = '0;
      default:     cnt_d = cnt_q + CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign tick_o = at_top;

endmodule

// File: rtl/presc_top.sv
module presc_top #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2,
  localparam int CNT_W    = BYTE_W * NUM_BYTES,
  localparam int AW       = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              update_i,
  output logic              tick_o
);

  logic [CNT_W-1:0] pre_ratio;
  logic [CNT_W-1:0] act_ratio;
  logic [CNT_W-1:0] div_cnt;

  presc_byte_stage #(
    .BYTE_W   (BYTE_W),
    .NUM_BYTES(NUM_BYTES)
  ) stage_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .preload_o(pre_ratio)
  );

  presc_ratio_shadow #(
    .CNT_W(CNT_W)
  ) shadow_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (update_i),
    .preload_i(pre_ratio),
    .active_o (act_ratio)
  );

  presc_div_counter #(
    .CNT_W(CNT_W)
  ) div_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(update_i),
    .limit_i  (act_ratio),
    .cnt_o    (div_cnt),
    .tick_o   (tick_o)
  );

endmodule

// File: rtl/presc_chk.sv
module presc_chk #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16,
  parameter int AW     = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [AW-1:0]     wr_addr_i,
  input logic [BYTE_W-1:0] wr_data_i,
  input logic              update_i,
  input logic              tick_o,
  input logic [CNT_W-1:0]  pre_ratio,
  input logic [CNT_W-1:0]  act_ratio,
  input logic [CNT_W-1:0]  div_cnt
);

  // R7
  update_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> (div_cnt == '0) && (act_ratio == $past(pre_ratio)));

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!update_i && !tick_o) |=> div_cnt == $past(div_cnt) + CNT_W'(1));

  // R2
  wrap_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !update_i) |=> div_cnt == '0);

  // R6
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(act_ratio));

  // R4
  high_stage_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0) |=> $stable(pre_ratio));

  // R5
  low_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == '0) |=> pre_ratio[BYTE_W-1:0] == $past(wr_data_i));

  // R3
  zero_ratio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_ratio == '0 && !update_i) |=> tick_o);

endmodule

bind presc_top presc_chk #(
  .BYTE_W(BYTE_W),
  .CNT_W (CNT_W),
  .AW    (AW)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .update_i (update_i),
  .tick_o   (tick_o),
  .pre_ratio(pre_ratio),
  .act_ratio(act_ratio),
  .div_cnt  (div_cnt)
);

// File: tb/presc_top_tb_top.sv
module presc_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  typedef struct {
    logic  exp;
    string req;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [0:0] wr_addr_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       update_i = 1'b0;
  logic       tick_o;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  exp_t  sb_q[$];

  // reference state, derived from the requirements
  logic [7:0]  m_stage = 8'h00;
  logic [15:0] m_pre   = 16'h0000;
  logic [15:0] m_act   = 16'h0000;
  logic [15:0] m_cnt   = 16'h0000;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  presc_top dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .update_i (update_i),
    .tick_o   (tick_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: tick_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected tick
  task automatic cyc(input bit we, input bit hi, input logic [7:0] d,
                     input bit upd, input string req);
    logic [15:0] old_pre;
    @(negedge clk_i);
    wr_en_i   = we;
    wr_addr_i = hi;
    wr_data_i = d;
    update_i  = upd;
    @(posedge clk_i);
    old_pre = m_pre;
    if (we && hi)  m_stage = d;
    if (we && !hi) m_pre = {m_stage, d};
    if (upd) begin
      m_act = old_pre;
      m_cnt = 16'h0000;
    end else if (m_cnt == m_act) begin
      m_cnt = 16'h0000;
    end else begin
      m_cnt = m_cnt + 16'h0001;
    end
    sb_q.push_back('{exp: (m_cnt == m_act), req: req});
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, 1'b0, req);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(tick_o, e.exp, e.req);
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 check(tick_o, 1'b1, "R1 reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    idle(5, "R1 R3 after reset");

    // complete ratio 3 in preload; no effect before update
    cyc(1'b1, 1'b1, 8'h00, 1'b0, "R4 high byte");
    cyc(1'b1, 1'b0, 8'h03, 1'b0, "R5 low byte");
    idle(6, "R6 preload not active");
    cyc(1'b0, 1'b0, 8'h00, 1'b1, "R7 update");
    idle(12, "R2 period 4");

    // orphan high byte
    cyc(1'b1, 1'b1, 8'h01, 1'b0, "R4 orphan high");
    idle(3, "R4 R6");
    cyc(1'b0, 1'b0, 8'h00, 1'b1, "R8 update after orphan");
    idle(10, "R8 ratio kept");

    // complete 0x0102, then a low write on the update edge
    cyc(1'b1, 1'b0, 8'h02, 1'b0, "R5 low completes 0x0102");
    idle(2, "R6");
    cyc(1'b1, 1'b0, 8'h05, 1'b1, "R10 write with update");
    idle(600, "R10 ratio 0x0102");
    cyc(1'b0, 1'b0, 8'h00, 1'b1, "R7 update to 0x0105");
    idle(300, "R2 ratio 0x0105");

    // back to ratio 0
    cyc(1'b1, 1'b1, 8'h00, 1'b0, "R4");
    cyc(1'b1, 1'b0, 8'h00, 1'b0, "R5");
    cyc(1'b0, 1'b0, 8'h00, 1'b1, "R7");
    idle(6, "R3 ratio 0");

    // mid-period restart
    cyc(1'b1, 1'b0, 8'h09, 1'b0, "R5");
    cyc(1'b0, 1'b0, 8'h00, 1'b1, "R7");
    idle(4, "R2");
    cyc(1'b0, 1'b0, 8'h00, 1'b1, "R7 mid-period restart");
    idle(25, "R7 R2 ratio 9");

    // full-scale ratio
    cyc(1'b1, 1'b1, 8'hFF, 1'b0, "R4");
    cyc(1'b1, 1'b0, 8'hFF, 1'b0, "R5");
    cyc(1'b0, 1'b0, 8'h00, 1'b1, "R7");
    idle(131090, "R9 ratio 0xFFFF");

    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule